// File: doc/BRIEF.md
# Single-Master I2C Message Sequencer

This block runs one whole I2C message as the sole master on a two-wire bus. A caller pulses `start` with a byte count that includes the address byte. The sequencer pulls the address byte through a valid/ready write port, and bit 0 of that byte selects the direction. It then issues a START and shifts the address out. After that it either writes further bytes taken from the same port, checking the acknowledge after each one, or reads bytes from the target and hands each one out with a one-cycle valid pulse. It always finishes with a STOP and then a single-cycle `done` pulse.

The bus pins are open-drain: the block only ever pulls a line low (`scl_pull`, `sda_pull`) and reads the real line levels back through `scl_i` and `sda_i`. Whenever it releases SCL it waits until the line is seen high, so a target that stretches the clock slows the bus down. The two SCL phases and the START/STOP hold time are counted in system clocks. `fast_mode` chooses between two parameter sets for these times. A two-bit error code tells the failure causes apart. The code is cleared when a message is accepted and holds its value until the next one.

Top module: `i2c_msg_seq`

## Requirements
- R1: A `start` with `msg_len` of 0 or 1 produces `done` in the next cycle with error code 1 (no data). It causes no START, no bus activity and no write handshake.
- R2: The first byte of a message is taken through the write handshake, and its bit 0 selects the direction (1 = read from target, 0 = write to target). In read mode exactly one write handshake happens.
- R3: Each message of length 2 or more begins with exactly one START: SDA falls while SCL is high. While SCL is high during a data or acknowledge bit, the master's SDA output does not change.
- R4: In write mode every byte, the address included, goes out MSB first, and a write byte is fetched only after the previous byte was acknowledged. Without a NACK, exactly `msg_len` handshakes occur and the target receives those bytes in order.
- R5: When the address byte is not acknowledged, the message ends with error code 2 (address NACK) and no further byte is fetched or read.
- R6: When a written data byte is not acknowledged, the message ends with error code 3 (data NACK). No later byte is fetched, and this holds even when the rejected byte is the last one.
- R7: In read mode `msg_len`-1 bytes are emitted MSB first, each with a one-cycle `rd_valid`. The master acknowledges every received byte (SDA low) except the last, which gets a NACK (SDA left high).
- R8: Every message of length 2 or more, aborted or not, ends with exactly one STOP (SDA rises while SCL is high) before `done`. Both lines are released while `done` is high.
- R9: The error code is 0 after a successful message, even when the previous message failed. It is cleared in the cycle after an accepted `start` and holds until the next one.
- R10: Every SCL low phase lasts at least the selected low time and every SCL high phase at least the selected high time. With `fast_mode` = 1 the fast set (default 5/4 clocks) is used; otherwise the standard set (default 10/8 clocks) is used.
- R11: After reset both lines are released and `done`, `wr_ready`, `rd_valid` and the error code are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 selects the fast timing set |
| start | input | 1 | Begin a message (taken when idle) |
| msg_len | input | LEN_W | Byte count including the address byte |
| busy | output | 1 | A message is in progress |
| wr_ready | output | 1 | Sequencer wants the next byte to send |
| wr_valid | input | 1 | Caller offers `wr_data` |
| wr_data | input | 8 | Address or write byte |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a received byte |
| rd_data | output | 8 | Received byte |
| done | output | 1 | One-cycle pulse at the end of a message |
| err | output | 2 | 0 ok, 1 no data, 2 address NACK, 3 data NACK |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |

## Verification
The finishing-count test and the NACK test are evaluated on the same acknowledge edge. When the target rejects the final byte of a write, the byte count reaches zero in the same cycle the NACK is sampled. A target model that rejects the last data byte provokes this. The result is judged correct when the bench sees error code 3, exactly one STOP and no extra handshake. In the read direction the last byte's output pulse and the master's own NACK fall on the same acknowledge slot. For that case the bench checks the recorded acknowledge pattern together with the count of emitted bytes.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH_A,
        S_ST_REL,
        S_ST_SETUP,
        S_ST_HOLD,
        S_ST_SCLLO,
        S_BIT_LOW,
        S_BIT_RISE,
        S_BIT_HIGH,
        S_FETCH_D,
        S_SP_LOW,
        S_SP_RISE,
        S_SP_HOLD,
        S_SP_FREE,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_NO_DATA   = 2'd1,
        ERR_ADDR_NACK = 2'd2,
        ERR_DATA_NACK = 2'd3
    } seq_err_e;

endpackage

// File: rtl/i2c_seq_timer.sv
`timescale 1ns/1ps
module i2c_seq_timer #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic          expired
);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R10: a loaded phase length is what the counter then holds
    a_r10_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/i2c_msg_seq.sv
`timescale 1ns/1ps
module i2c_msg_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W       = 8,
    parameter int DW          = 8,
    parameter int T_LOW_STD   = 10,
    parameter int T_HIGH_STD  = 8,
    parameter int T_HOLD_STD  = 8,
    parameter int T_LOW_FAST  = 5,
    parameter int T_HIGH_FAST = 4,
    parameter int T_HOLD_FAST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_mode,
    input  logic             start,
    input  logic [LEN_W-1:0] msg_len,
    output logic             busy,
    output logic             wr_ready,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic [1:0]       err,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_pull,
    output logic             sda_pull
);

    localparam logic [DW-1:0]    LOW_S  = DW'(T_LOW_STD);
    localparam logic [DW-1:0]    HIGH_S = DW'(T_HIGH_STD);
    localparam logic [DW-1:0]    HOLD_S = DW'(T_HOLD_STD);
    localparam logic [DW-1:0]    LOW_F  = DW'(T_LOW_FAST);
    localparam logic [DW-1:0]    HIGH_F = DW'(T_HIGH_FAST);
    localparam logic [DW-1:0]    HOLD_F = DW'(T_HOLD_FAST);
    localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);
    localparam logic [3:0]       ACK_IX = 4'd8;

    typedef struct packed {
        seq_state_e       st;
        logic [7:0]       sh;
        logic [LEN_W-1:0] left;
        logic [3:0]       bitn;
        logic             rd_mode;
        logic             is_addr;
        logic             sda;
        logic             rdv;
        seq_err_e         err;
    } regs_t;

    localparam regs_t RESET_V = '{st: S_IDLE, sh: '0, left: '0, bitn: '0,
                                  rd_mode: 1'b0, is_addr: 1'b0, sda: 1'b0,
                                  rdv: 1'b0, err: ERR_NONE};

    regs_t         q, n;
    logic          t_load, t_exp, wr_phase, drive_bit;
    logic [DW-1:0] t_val;

    function automatic logic [DW-1:0] phase_delay(seq_state_e s, logic f);
        case (s)
            S_BIT_LOW, S_SP_LOW:              return f ? LOW_F  : LOW_S;
            S_BIT_HIGH, S_ST_SETUP, S_SP_FREE: return f ? HIGH_F : HIGH_S;
            S_ST_HOLD, S_SP_HOLD:             return f ? HOLD_F : HOLD_S;
            default:                          return '0;
        endcase
    endfunction

    i2c_seq_timer #(.DW(DW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    assign wr_phase  = !q.rd_mode || q.is_addr;
    assign drive_bit = (q.bitn == ACK_IX) ? (!wr_phase && (q.left != ONE))
                                          : (wr_phase && !q.sh[7]);

    always_comb begin
        n     = q;
        n.rdv = 1'b0;
        case (q.st)
            S_IDLE: if (start) begin
                n.err = ERR_NONE;
                if (msg_len <= ONE) begin
                    n.err = ERR_NO_DATA;
                    n.st  = S_DONE;
                end else begin
                    n.left    = msg_len;
                    n.is_addr = 1'b1;
                    n.st      = S_FETCH_A;
                end
            end
            S_FETCH_A: if (wr_valid) begin
                n.sh      = wr_data;
                n.rd_mode = wr_data[0];
                n.st      = S_ST_REL;
            end
            S_ST_REL:   if (scl_i) n.st = S_ST_SETUP;
            S_ST_SETUP: if (t_exp) n.st = S_ST_HOLD;
            S_ST_HOLD: begin
                n.sda = 1'b1;
                if (t_exp) n.st = S_ST_SCLLO;
            end
            S_ST_SCLLO: begin
                n.bitn = '0;
                n.st   = S_BIT_LOW;
            end
            S_BIT_LOW: begin
                n.sda = drive_bit;
                if (t_exp) n.st = S_BIT_RISE;
            end
            S_BIT_RISE: if (scl_i) n.st = S_BIT_HIGH;
            S_BIT_HIGH: if (t_exp) begin
                if (q.bitn != ACK_IX) begin
                    n.sh   = {q.sh[6:0], sda_i};
                    n.bitn = q.bitn + 4'd1;
                    n.st   = S_BIT_LOW;
                end else begin
                    n.bitn    = '0;
                    n.is_addr = 1'b0;
                    n.left    = q.left - ONE;
                    if (wr_phase && sda_i) begin
                        n.err = q.is_addr ? ERR_ADDR_NACK : ERR_DATA_NACK;
                        n.st  = S_SP_LOW;
                    end else begin
                        n.rdv = !wr_phase;
                        if (q.left == ONE)  n.st = S_SP_LOW;
                        else if (q.rd_mode) n.st = S_BIT_LOW;
                        else                n.st = S_FETCH_D;
                    end
                end
            end
            S_FETCH_D: if (wr_valid) begin
                n.sh = wr_data;
                n.st = S_BIT_LOW;
            end
            S_SP_LOW: begin
                n.sda = 1'b1;
                if (t_exp) n.st = S_SP_RISE;
            end
            S_SP_RISE: if (scl_i) n.st = S_SP_HOLD;
            S_SP_HOLD: if (t_exp) n.st = S_SP_FREE;
            S_SP_FREE: begin
                n.sda = 1'b0;
                if (t_exp) n.st = S_DONE;
            end
            S_DONE:  n.st = S_IDLE;
            default: n.st = S_IDLE;
        endcase
        t_val  = phase_delay(n.st, fast_mode);
        t_load = (n.st != q.st) && (t_val != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_V;
        else        q <= n;
    end

    assign busy     = (q.st != S_IDLE);
    assign wr_ready = (q.st == S_FETCH_A) || (q.st == S_FETCH_D);
    assign rd_valid = q.rdv;
    assign rd_data  = q.sh;
    assign done     = (q.st == S_DONE);
    assign err      = q.err;
    assign scl_pull = (q.st == S_ST_SCLLO) || (q.st == S_BIT_LOW) ||
                      (q.st == S_FETCH_D)  || (q.st == S_SP_LOW);
    assign sda_pull = q.sda;

    a_r1_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && start && msg_len <= ONE) |=> (done && err == ERR_NO_DATA));

    a_r9_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && start && msg_len > ONE) |=> (err == ERR_NONE));

    a_r4_one_byte_per_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && wr_valid) |=> !wr_ready);

    a_r3_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_BIT_HIGH) |-> $stable(sda_pull));

    a_r8_done_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_pull && !sda_pull));

    a_r7_rd_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> q.rd_mode);

endmodule

// File: tb/tb_i2c_msg_seq.sv
`timescale 1ns/1ps
module tb_i2c_msg_seq;

    localparam int TLS = 10, THS = 8, TLF = 5, THF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fast_mode = 1'b0, start = 1'b0, wr_valid = 1'b0;
    logic [7:0] msg_len = '0, wr_data = '0, rd_data;
    logic busy, wr_ready, rd_valid, done, scl_pull, sda_pull;
    logic [1:0] err;
    logic s_drive = 1'b0;
    wire scl_line = ~scl_pull;
    wire sda_line = ~(sda_pull | s_drive);

    always #10 clk = ~clk;

    i2c_msg_seq #(.T_LOW_STD(TLS), .T_HIGH_STD(THS), .T_LOW_FAST(TLF), .T_HIGH_FAST(THF)) dut (
        .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .start(start), .msg_len(msg_len),
        .busy(busy), .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
        .scl_i(scl_line), .sda_i(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull));

    int checks = 0, errors = 0;

    // target model and SCL phase monitor (sole writer of its variables)
    logic mon_en = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] s_nack_at = 8'hFF, s_rd_base = '0, s_rx = '0;
    logic [7:0] s_log [16];
    logic s_mack [16];
    logic s_active = 1'b0, s_rd_mode = 1'b0, s_rd_done = 1'b0;
    int s_bitn = 0, s_byten = 0, start_cnt = 0, stop_cnt = 0;
    int epoch = 0, seen_epoch = 0, min_low = 1000000, min_high = 1000000;
    time t_edge = 0;
    logic edge_ok = 1'b0;

    function automatic logic [7:0] rbyte(input logic [7:0] base, input int k);
        return base ^ (8'(k) * 8'h25);
    endfunction

    always @(scl_line or sda_line) begin
        if (mon_en) begin
            if (seen_epoch != epoch) begin
                seen_epoch = epoch; min_low = 1000000; min_high = 1000000; edge_ok = 1'b0;
            end
            if (scl_line !== p_scl) begin
                if (edge_ok) begin
                    if (scl_line) min_low  = (int'((($time - t_edge) / 20)) < min_low)  ? int'(($time - t_edge) / 20) : min_low;
                    else          min_high = (int'((($time - t_edge) / 20)) < min_high) ? int'(($time - t_edge) / 20) : min_high;
                end
                t_edge = $time; edge_ok = 1'b1;
                if (scl_line && s_active) begin
                    if (s_bitn < 8) begin
                        s_rx = {s_rx[6:0], sda_line}; s_bitn++;
                    end else begin
                        if (s_byten == 0 || !s_rd_mode) begin
                            if (s_byten < 16) s_log[s_byten] = s_rx;
                            if (s_byten == 0) s_rd_mode = s_rx[0];
                            if (s_byten == int'(s_nack_at)) s_active = 1'b0;
                        end else begin
                            if (s_byten < 16) s_mack[s_byten] = sda_line;
                            if (sda_line) s_rd_done = 1'b1;
                        end
                        s_bitn = 0; s_byten++;
                    end
                end else if (!scl_line) begin
                    s_drive = 1'b0;
                    if (s_active) begin
                        if (s_bitn == 8 && (s_byten == 0 || !s_rd_mode))
                            s_drive = (s_byten != int'(s_nack_at));
                        else if (s_rd_mode && s_byten >= 1 && s_bitn < 8 && !s_rd_done)
                            s_drive = !rbyte(s_rd_base, s_byten)[7 - s_bitn];
                    end
                end
            end else if (sda_line !== p_sda && scl_line) begin
                if (!sda_line) begin
                    start_cnt++; s_active = 1'b1; s_bitn = 0; s_byten = 0;
                    s_rd_mode = 1'b0; s_rd_done = 1'b0; s_drive = 1'b0;
                end else begin
                    stop_cnt++; s_active = 1'b0; s_drive = 1'b0;
                end
            end
        end
        p_scl = scl_line; p_sda = sda_line;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] wbyte(input logic [7:0] addr, input logic [7:0] base, input int i);
        return (i == 0) ? addr : base + 8'(i) * 8'h11;
    endfunction

    int fetch_n, rd_n;
    logic [1:0] got_err;
    logic [7:0] rd_buf [16];

    task automatic run_txn(input logic [7:0] len, input logic [7:0] addr, input logic [7:0] base,
                           input logic [7:0] nack, input logic f);
        logic prev_ready = 1'b0;
        bit finished = 0;
        fetch_n = 0; rd_n = 0; got_err = 2'bxx;
        epoch++;
        s_nack_at = nack; s_rd_base = base;
        @(negedge clk);
        fast_mode = f; start = 1'b1; msg_len = len;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (wr_valid && prev_ready) fetch_n++;
            prev_ready = wr_ready;
            wr_valid = wr_ready;
            wr_data = wbyte(addr, base, fetch_n);
            if (rd_valid && rd_n < 16) begin rd_buf[rd_n] = rd_data; rd_n++; end
            if (done) begin got_err = err; finished = 1; break; end
            @(negedge clk);
        end
        wr_valid = 1'b0;
        chk(finished, "R8 done reached", int'(finished), 1);
    endtask

    typedef struct packed {
        logic [7:0] len;
        logic [7:0] addr;
        logic [7:0] base;
        logic [7:0] nack;
        logic       fast;
        logic [1:0] eerr;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd3, 8'hA4, 8'h5A, 8'hFF, 1'b0, 2'd0},
        '{8'd4, 8'hA5, 8'h3C, 8'hFF, 1'b0, 2'd0},
        '{8'd2, 8'h42, 8'h81, 8'h00, 1'b1, 2'd2},
        '{8'd4, 8'h42, 8'h10, 8'h02, 1'b0, 2'd3},
        '{8'd3, 8'h42, 8'hF0, 8'h02, 1'b1, 2'd3},
        '{8'd2, 8'h91, 8'hC3, 8'hFF, 1'b1, 2'd0},
        '{8'd3, 8'h91, 8'h77, 8'h00, 1'b0, 2'd2}
    };

    initial begin
        #(200000 * 20);
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        int std_low;
        std_low = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!scl_pull && !sda_pull, "R11 lines released", int'(scl_pull | sda_pull), 0);
        chk(!done && !wr_ready && !rd_valid, "R11 handshakes idle", int'({done, wr_ready, rd_valid}), 0);
        chk(err == 2'd0, "R11 error code", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        for (int v = 0; v < NV; v++) begin
            int s0, p0, exp_fetch, lenv;
            string etag;
            s0 = start_cnt; p0 = stop_cnt; lenv = int'(VECS[v].len);
            run_txn(VECS[v].len, VECS[v].addr, VECS[v].base, VECS[v].nack, VECS[v].fast);
            etag = (VECS[v].eerr == 2'd2) ? "R5 error code" :
                   (VECS[v].eerr == 2'd3) ? "R6 error code" : "R9 error code";
            chk(got_err == VECS[v].eerr, etag, int'(got_err), int'(VECS[v].eerr));
            chk(start_cnt - s0 == 1, "R3 one START", start_cnt - s0, 1);
            chk(stop_cnt - p0 == 1, "R8 one STOP", stop_cnt - p0, 1);
            if (VECS[v].addr[0]) exp_fetch = 1;
            else if (VECS[v].nack != 8'hFF) exp_fetch = int'(VECS[v].nack) + 1;
            else exp_fetch = lenv;
            chk(fetch_n == exp_fetch, "R2 R4 R6 handshake count", fetch_n, exp_fetch);
            if (!VECS[v].addr[0]) begin
                for (int i = 0; i < exp_fetch; i++)
                    chk(s_log[i] == wbyte(VECS[v].addr, VECS[v].base, i), "R4 byte on bus",
                        int'(s_log[i]), int'(wbyte(VECS[v].addr, VECS[v].base, i)));
            end else begin
                chk(s_log[0] == VECS[v].addr, "R2 address sent", int'(s_log[0]), int'(VECS[v].addr));
                if (VECS[v].nack == 8'hFF) begin
                    chk(rd_n == lenv - 1, "R7 bytes emitted", rd_n, lenv - 1);
                    for (int k = 1; k < lenv; k++) begin
                        chk(rd_buf[k-1] == rbyte(VECS[v].base, k), "R7 read value",
                            int'(rd_buf[k-1]), int'(rbyte(VECS[v].base, k)));
                        chk(s_mack[k] == (k == lenv - 1), "R7 master ack/nack",
                            int'(s_mack[k]), int'(k == lenv - 1));
                    end
                end else begin
                    chk(rd_n == 0, "R5 nothing read", rd_n, 0);
                end
            end
            if (v == 0) begin
                std_low = min_low;
                chk(min_low >= TLS, "R10 std low phase", min_low, TLS);
                chk(min_high >= THS, "R10 std high phase", min_high, THS);
            end
            if (v == 2) begin
                chk(min_low >= TLF, "R10 fast low phase", min_low, TLF);
                chk(min_high >= THF, "R10 fast high phase", min_high, THF);
                chk(min_low < std_low, "R10 fast shorter than std", min_low, std_low);
            end
        end

        // R1: too short messages
        for (int l = 0; l < 2; l++) begin
            int s0;
            s0 = start_cnt;
            run_txn(8'(l), 8'h40, 8'h00, 8'hFF, 1'b0);
            chk(got_err == 2'd1, "R1 no-data code", int'(got_err), 1);
            chk(start_cnt == s0, "R1 no START", start_cnt - s0, 0);
            chk(fetch_n == 0, "R1 no handshake", fetch_n, 0);
        end

        // R9: a failure followed by a success clears the code
        run_txn(8'd2, 8'h42, 8'h00, 8'h00, 1'b1);
        chk(got_err == 2'd2, "R9 prior failure", int'(got_err), 2);
        run_txn(8'd2, 8'h42, 8'h33, 8'hFF, 1'b1);
        chk(got_err == 2'd0, "R9 cleared on success", int'(got_err), 0);
        @(negedge clk);
        chk(err == 2'd0 && !busy, "R9 code held after done", int'(err), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule